// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block stores the protection fields of a serial flash status register and decides, request by request, whether a modifying operation may go ahead. The command decoder sends it three kinds of requests: status-register writes with a data byte, program or sector-erase requests with a byte address, and chip-erase requests. The block answers each one with a single-cycle grant or deny pulse. It also presents the protection fields as a status byte that can be read at any time.

A three-bit protection code selects a region at the top of a 2 MiB array. The array is 32 blocks of 64 KiB, and the region ranges from no blocks to the whole array. A lock bit can freeze the code and the lock bit itself, but only while the external write-protect pin is low. The pin passes through a synchronizer before any decision uses it. The write-enable latch, busy timing and the array itself are outside this block.

Top module: `flash_wp_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, status_o reads 0x1C (code 111, lock 0), and grant_o and deny_o are low.
- R2: status_o carries code bit 0 at bit 2, code bit 1 at bit 3, code bit 2 at bit 4 and the lock bit at bit 7. Bits 0, 1, 5 and 6 always read 0, whatever data is written.
- R3: The code selects which blocks are protected; the block index is addr_i[20:16]. Code 000 protects no block. Code 001 protects block 31. Code 010 protects blocks 30 and up. Code 011 protects blocks 28 and up. Code 100 protects blocks 24 and up. Code 101 protects blocks 16 and up. Codes 110 and 111 protect every block.
- R4: A program or sector-erase request is denied when its block is protected and granted otherwise. addr_i[15:0] has no effect on the decision.
- R5: A chip-erase request is granted only when the code is 000. The address has no effect on it.
- R6: A status write is granted when the synchronized pin is high or the lock bit is 0. A granted write loads the code from data bits 4..2 and the lock bit from data bit 7.
- R7: A status write is denied when the synchronized pin is low and the lock bit is 1. A denied write leaves status_o unchanged.
- R8: wp_pin_i passes through two flops. A request sampled at clock edge k uses the pin level that was sampled at edge k-2.
- R9: Each clock edge that samples at least one request strobe produces, in the following cycle, exactly one of grant_o and deny_o for one cycle. An edge that samples no strobe produces neither.
- R10: Every request is judged against the status bits held before any status write sampled at the same edge. When several strobes are sampled together, the result is a grant only if each operation is allowed on its own. An allowed status write takes effect even if another operation in the same cycle is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wp_pin_i | input | 1 | Asynchronous write-protect pin level; low makes the lock bit effective |
| sr_wr_i | input | 1 | Status-register write strobe |
| sr_data_i | input | 8 | Status-register write data |
| prog_req_i | input | 1 | Program request strobe |
| serase_req_i | input | 1 | Sector-erase request strobe |
| cerase_req_i | input | 1 | Chip-erase request strobe |
| addr_i | input | 21 | Byte address of the program or sector erase |
| grant_o | output | 1 | Request allowed, one-cycle pulse |
| deny_o | output | 1 | Request refused, one-cycle pulse |
| status_o | output | 8 | Status byte holding the protection fields |

## Verification
The bench uses the default parameters: a 21-bit address with a 16-bit block offset, which gives 32 blocks, and a two-stage pin synchronizer. With these values each code boundary falls on a block edge that random addresses hit often. Directed accesses at the first protected block and the block just below it make every boundary visible. The short synchronizer lets the bench toggle the pin in the same cycle as a status write and see the old and new levels take effect, without long idle stretches.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned LOCK_BIT = 7;
  localparam int unsigned STAT_W   = 8;

  typedef struct packed {
    logic              lock;
    logic [CODE_W-1:0] code;
  } prot_state_t;

  localparam prot_state_t PROT_RST = '{lock: 1'b0, code: '1};
endpackage

// File: rtl/wp_sync.sv
module wp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d_i;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/prot_range.sv
module prot_range
  import flash_wp_pkg::*;
#(
  parameter int unsigned BLK_W = 5
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [BLK_W-1:0]  blk_i,
  output logic              hit_o,
  output logic              clear_o
);
  localparam logic [BLK_W:0]    NUM_BLK   = (BLK_W+1)'(1) << BLK_W;
  localparam logic [CODE_W-1:0] CODE_FULL = CODE_W'(BLK_W + 1);

  logic [BLK_W:0] prot_cnt;
  logic [BLK_W:0] low_bound;

  // protected count doubles per code step, saturating at the whole array
  always_comb begin
    if (code_i == '0)            prot_cnt = '0;
    else if (code_i >= CODE_FULL) prot_cnt = NUM_BLK;
    else                         prot_cnt = (BLK_W+1)'(1) << (code_i - 1'b1);
  end

  assign low_bound = NUM_BLK - prot_cnt;
  assign hit_o     = {1'b0, blk_i} >= low_bound;
  assign clear_o   = (code_i == '0);
endmodule

// File: rtl/prot_regs.sv
module prot_regs
  import flash_wp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              lock_d_i,
  input  logic [CODE_W-1:0] code_d_i,
  input  logic              wp_hi_i,
  output prot_state_t       state_o,
  output logic              wr_ok_o
);
  prot_state_t state_q;

  assign wr_ok_o = wp_hi_i | ~state_q.lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PROT_RST;
    else if (wr_i && wr_ok_o) begin
      state_q.lock <= lock_d_i;
      state_q.code <= code_d_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import flash_wp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 21,
  parameter int unsigned BLK_SHIFT = 16,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_pin_i,
  input  logic              sr_wr_i,
  input  logic [STAT_W-1:0] sr_data_i,
  input  logic              prog_req_i,
  input  logic              serase_req_i,
  input  logic              cerase_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned BLK_W = ADDR_W - BLK_SHIFT;

  logic        wp_s;
  prot_state_t state;
  logic        wr_ok, blk_hit, code_clear;
  logic        any_req, all_ok;
  logic        grant_q, deny_q;

  wp_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wp_pin_i),
    .q_o   (wp_s)
  );

  prot_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sr_wr_i),
    .lock_d_i(sr_data_i[LOCK_BIT]),
    .code_d_i(sr_data_i[CODE_LSB +: CODE_W]),
    .wp_hi_i (wp_s),
    .state_o (state),
    .wr_ok_o (wr_ok)
  );

  prot_range #(.BLK_W(BLK_W)) u_range (
    .code_i (state.code),
    .blk_i  (addr_i[ADDR_W-1:BLK_SHIFT]),
    .hit_o  (blk_hit),
    .clear_o(code_clear)
  );

  assign any_req = sr_wr_i | prog_req_i | serase_req_i | cerase_req_i;
  assign all_ok  = (~sr_wr_i | wr_ok)
                 & (~(prog_req_i | serase_req_i) | ~blk_hit)
                 & (~cerase_req_i | code_clear);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= any_req & all_ok;
      deny_q  <= any_req & ~all_ok;
    end
  end

  always_comb begin
    status_o                        = '0;
    status_o[LOCK_BIT]              = state.lock;
    status_o[CODE_LSB +: CODE_W]    = state.code;
  end

  assign grant_o = grant_q;
  assign deny_o  = deny_q;

  logic unused_bits;
  assign unused_bits = ^{sr_data_i[6:5], sr_data_i[1:0], addr_i[BLK_SHIFT-1:0]};
endmodule

// File: rtl/flash_wp_chk.sv
module flash_wp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sr_wr_i,
  input logic       prog_req_i,
  input logic       serase_req_i,
  input logic       cerase_req_i,
  input logic       wp_s_i,
  input logic       grant_o,
  input logic       deny_o,
  input logic [7:0] status_o
);
  logic any_req;
  assign any_req = sr_wr_i | prog_req_i | serase_req_i | cerase_req_i;

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && deny_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_req |=> !grant_o && !deny_o);

  a_r9_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> grant_o || deny_o);

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_wr_i && !wp_s_i && status_o[7]) |=> deny_o && $stable(status_o));

  a_r5_cerase_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cerase_req_i && status_o[4:2] != 3'b000) |=> deny_o);

  a_r2_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & 8'h63) == 8'h00);
endmodule

bind flash_wp_ctrl flash_wp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sr_wr_i     (sr_wr_i),
  .prog_req_i  (prog_req_i),
  .serase_req_i(serase_req_i),
  .cerase_req_i(cerase_req_i),
  .wp_s_i      (wp_s),
  .grant_o     (grant_o),
  .deny_o      (deny_o),
  .status_o    (status_o)
);

// File: tb/flash_wp_ctrl_test.sv
module flash_wp_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wp_pin_i = 1'b1;
  logic        sr_wr_i = 1'b0;
  logic [7:0]  sr_data_i = '0;
  logic        prog_req_i = 1'b0, serase_req_i = 1'b0, cerase_req_i = 1'b0;
  logic [20:0] addr_i = '0;
  logic        grant_o, deny_o;
  logic [7:0]  status_o;

  int checks = 0, fails = 0;

  // reference model state
  logic [2:0] m_code = 3'b111;
  logic       m_lock = 1'b0;
  logic       m_s1 = 1'b0, m_s2 = 1'b0;
  logic       m_grant = 1'b0, m_deny = 1'b0;

  always #2 clk_i = ~clk_i;

  flash_wp_ctrl uut (
    .clk_i, .rst_ni, .wp_pin_i, .sr_wr_i, .sr_data_i, .prog_req_i,
    .serase_req_i, .cerase_req_i, .addr_i, .grant_o, .deny_o, .status_o
  );

  function automatic int first_prot(input logic [2:0] c);
    case (c)
      3'd0: return 32;
      3'd1: return 31;
      3'd2: return 30;
      3'd3: return 28;
      3'd4: return 24;
      3'd5: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_lock, 2'b00, m_code, 2'b00};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic any, ok;
    any = sr_wr_i | prog_req_i | serase_req_i | cerase_req_i;
    ok = 1'b1;
    if (sr_wr_i && !(m_s2 || !m_lock)) ok = 1'b0;
    if ((prog_req_i || serase_req_i) && int'(addr_i[20:16]) >= first_prot(m_code)) ok = 1'b0;
    if (cerase_req_i && m_code != 3'b000) ok = 1'b0;
    m_grant = any & ok;
    m_deny  = any & ~ok;
    if (sr_wr_i && (m_s2 || !m_lock)) begin
      m_code = sr_data_i[4:2];
      m_lock = sr_data_i[7];
    end
    m_s2 = m_s1;
    m_s1 = wp_pin_i;
  endtask

  // drive at negedge, step model at posedge, check at following negedge
  task automatic cycle(input logic sr, input logic [7:0] d, input logic p,
                       input logic se, input logic ce, input logic [20:0] a,
                       input logic pin, input string tag);
    string t;
    sr_wr_i = sr; sr_data_i = d; prog_req_i = p; serase_req_i = se;
    cerase_req_i = ce; addr_i = a; wp_pin_i = pin;
    if (tag != "") t = tag;
    else if (sr && !(m_s2 || !m_lock)) t = "R7";
    else if (sr) t = "R6";
    else if (ce) t = "R5";
    else if (p || se) t = "R4";
    else t = "R9";
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    check({t, " grant"}, {7'd0, grant_o}, {7'd0, m_grant});
    check({t, " deny"}, {7'd0, deny_o}, {7'd0, m_deny});
    check("R2 status", status_o, exp_status());
  endtask

  task automatic idle(input int n, input logic pin);
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, '0, pin, "R9");
  endtask

  initial begin
    #8000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check("R1 status", status_o, 8'h1C);
    check("R1 grant", {7'd0, grant_o}, 8'd0);
    check("R1 deny", {7'd0, deny_o}, 8'd0);
    rst_ni = 1'b1;
    idle(3, 1'b1);

    // R2: unused bits ignore writes
    cycle(1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R2");
    cycle(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R6");

    // R3/R4/R5 sweep over all codes at block boundaries
    for (int c = 0; c < 8; c++) begin
      int b;
      cycle(1'b1, 8'(c << 2), 1'b0, 1'b0, 1'b0, '0, 1'b1, "R6");
      b = first_prot(3'(c));
      if (b < 32) begin
        cycle(1'b0, '0, 1'b1, 1'b0, 1'b0, {5'(b), 16'h0000}, 1'b1, "R3");
        cycle(1'b0, '0, 1'b0, 1'b1, 1'b0, {5'(b), 16'hA5A5}, 1'b1, "R3");
      end
      if (b > 0) begin
        cycle(1'b0, '0, 1'b1, 1'b0, 1'b0, {5'(b-1), 16'hFFFF}, 1'b1, "R3");
        cycle(1'b0, '0, 1'b0, 1'b1, 1'b0, {5'(b-1), 16'h0001}, 1'b1, "R4");
      end
      cycle(1'b0, '0, 1'b0, 1'b0, 1'b1, 21'h1FFFFF, 1'b1, "R5");
    end

    // R7: lock holds while pin low
    cycle(1'b1, 8'h8C, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R6");
    idle(3, 1'b0);
    cycle(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R7");
    cycle(1'b1, 8'h1C, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R7");
    idle(3, 1'b1);
    cycle(1'b1, 8'h80, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R6");

    // R8: pin change takes two edges to matter
    cycle(1'b1, 8'h84, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R8");
    cycle(1'b1, 8'h88, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R8");
    cycle(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, '0, 1'b0, "R8");
    idle(3, 1'b1);
    cycle(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, '0, 1'b1, "R6");

    // R10: same-cycle write and program use old code; combined strobes
    cycle(1'b1, 8'h1C, 1'b1, 1'b0, 1'b0, 21'h1F0000, 1'b1, "R10");
    cycle(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 21'h1F0000, 1'b1, "R10");
    cycle(1'b1, 8'h00, 1'b0, 1'b0, 1'b1, '0, 1'b1, "R10");
    cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, '0, 1'b1, "R10");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic pin;
      pin = ($urandom_range(0, 15) == 0) ? ~wp_pin_i : wp_pin_i;
      cycle(($urandom_range(0, 5) == 0), 8'($urandom), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 5) == 0), ($urandom_range(0, 9) == 0),
            21'($urandom), pin, "");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule